// File: doc/BRIEF.md
# HDLC Frame Receiver

This block recovers frames from a serial NRZ line that delivers one bit per `bit_en` strobe. It looks for the 01111110 flag at every bit position, removes the zeros a transmitter stuffs after five ones, and packs the remaining bits into bytes, least significant bit first. Each byte updates a 16-bit CRC. A closing flag gives a good result only when the final CRC register equals F0B8 hex. Bytes go out on a strobed interface with first and last markers. The two frame-check bytes are held back and never leave the block. An end-of-packet pulse and a two-bit end code report how each frame finished: 0 good, 1 bad, 2 short, 3 aborted.

An optional filter checks the first byte of each frame against a programmed address. In wide mode it compares seven bits and in narrow mode six. An all-ones first byte is always accepted. Separate line-state outputs report an abort (seven ones in a row) and an idle line (fifteen ones in a row).

The frame tracker is a three-state machine:
- `FR_HUNT`: no sync. A flag moves it to `FR_OPEN` (transition *acquire*).
- `FR_OPEN`: collecting bytes and delivering them. A flag keeps it in `FR_OPEN` and closes any frame in progress (*close*). A first byte that fails the filter moves it to `FR_SKIP` (*reject*). An abort moves it to `FR_HUNT` (*abandon*).
- `FR_SKIP`: discards the frame without output. A flag moves it to `FR_OPEN` (*resync*) and an abort moves it to `FR_HUNT` (*abandon*).

Top module: `hdlc_rx`

## Requirements
- R1: Frames are delimited by the 01111110 pattern found at any bit offset. Nothing is delivered before the first flag, and flag bits are never delivered, including back-to-back flags.
- R2: Inside a frame, a zero that directly follows five consecutive ones is dropped. Data bytes holding runs of ones come out unchanged.
- R3: A seventh consecutive one is an abort. It sets `line_abort`, which stays high until the next flag. In `FR_OPEN` it ends the frame with `eop` and end code 3, with no byte marked last, and the tracker returns to `FR_HUNT`.
- R4: `abort_frame` pulses together with an abort `eop` only if at least four whole bytes were assembled after the opening flag. It stays low for an abort after fewer bytes.
- R5: `line_idle` rises on the fifteenth consecutive one and falls on the next zero. It is low after fourteen ones.
- R6: The CRC (reflected form, polynomial x^16+x^12+x^5+1, register preset to all ones) runs over all whole bytes, including the two FCS bytes. A residue of F0B8 hex gives end code 0; any other residue gives end code 1.
- R7: Bytes leave in arrival order with the two FCS bytes withheld. `out_first` marks the first delivered byte. `out_last` marks the last data byte, which is delivered on the closing flag.
- R8: With `filt_en` high, a frame is delivered only if bits 7..1 of its first byte equal `addr_hi` or the byte is FF hex. Bit 0 of the first byte is never compared. A rejected frame yields no bytes and no `eop`.
- R9: With `filt_en` and `filt_narrow` both high, only bits 7..2 of the first byte are compared, against `addr_hi[6:1]`.
- R10: On a closing flag, `eop` goes high if at least 24 destuffed bits lie between the flags, and `end_status` holds the end code. `eop` stays high for exactly one bit time: it is set on the strobe that ends the frame and cleared on the next strobe. Shorter runs end silently.
- R11: A closing flag after fewer than 32 destuffed bits gives end code 2.
- R12: A closing flag after 32 or more destuffed bits whose count is not a multiple of 8 gives end code 1.
- R13: All outputs are low after reset. Outputs change only on a clock edge where `bit_en` is high, and `out_valid` is high for a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe: `rx_bit` holds a new line bit |
| rx_bit | input | 1 | Serial line bit |
| filt_en | input | 1 | Enable first-byte address filter |
| filt_narrow | input | 1 | Compare six address bits instead of seven |
| addr_hi | input | 7 | Programmed address, bits 7..1 |
| out_valid | output | 1 | Delivered byte strobe, one clock |
| out_data | output | 8 | Delivered byte |
| out_first | output | 1 | Byte is the first of its frame |
| out_last | output | 1 | Byte is the last data byte of its frame |
| end_status | output | 2 | End code: 0 good, 1 bad, 2 short, 3 aborted |
| eop | output | 1 | End-of-packet pulse, one bit time |
| abort_frame | output | 1 | Abort after at least four bytes |
| line_abort | output | 1 | Abort line state |
| line_idle | output | 1 | Idle line state |

## Verification
A wrong bit position after a flag misaligns every byte of the frame. The bytes come out wrong and the frame ends with code 1 within one frame. A run counter that counts wrongly shows up as a missed flag: the frame never gets an `eop`, or a stuffed zero appears in the data within eight bits. A corrupted CRC register or held byte shows only at the closing flag, in `end_status` and in the last delivered byte. A wrong filter decision shows as bytes or an `eop` that appear or go missing four bytes into the frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        END_GOOD  = 2'd0,
        END_BAD   = 2'd1,
        END_SHORT = 2'd2,
        END_ABORT = 2'd3
    } end_code_t;

    localparam int BYTE_W     = 8;
    localparam int FCS_BYTES  = 2;
    localparam int HOLD_N     = FCS_BYTES + 1;
    localparam int FLAG_LEAD  = 6;   // flag bits pushed as data before the flag is seen
    localparam int STUFF_RUN  = 5;
    localparam int FLAG_RUN   = 6;
    localparam int ABORT_RUN  = 7;
    localparam int IDLE_RUN   = 15;
    localparam int EOP_BITS   = 24;
    localparam int MIN_BITS   = 32;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_RF = 16'h8408;
    localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_RF;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic ev_data,
    output logic ev_flag,
    output logic ev_abort,
    output logic line_abort,
    output logic line_idle
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX   = '1;
    localparam logic [RUN_W-1:0] L_STUFF   = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] L_FLAG    = RUN_W'(FLAG_RUN);
    localparam logic [RUN_W-1:0] L_PREABRT = RUN_W'(ABORT_RUN - 1);
    localparam logic [RUN_W-1:0] L_PREIDLE = RUN_W'(IDLE_RUN - 1);

    logic [RUN_W-1:0] run_q;

    always_comb begin
        ev_data  = bit_en && (run_q < L_STUFF);
        ev_flag  = bit_en && !rx_bit && (run_q == L_FLAG);
        ev_abort = bit_en &&  rx_bit && (run_q == L_PREABRT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            line_abort <= 1'b0;
            line_idle  <= 1'b0;
        end else if (bit_en) begin
            if (rx_bit) run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            else        run_q <= '0;
            if (ev_abort)     line_abort <= 1'b1;
            else if (ev_flag) line_abort <= 1'b0;
            if (rx_bit && run_q == L_PREIDLE) line_idle <= 1'b1;
            else if (!rx_bit)                 line_idle <= 1'b0;
        end
    end
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        rx_bit,
    input  logic        ev_data,
    input  logic        ev_flag,
    input  logic        ev_abort,
    input  logic        filt_en,
    input  logic        filt_narrow,
    input  logic [6:0]  addr_hi,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_first,
    output logic        out_last,
    output end_code_t   end_status,
    output logic        eop,
    output logic        abort_frame
);
    typedef enum logic [1:0] {FR_HUNT, FR_OPEN, FR_SKIP} fr_state_t;

    localparam logic [CNT_W-1:0] EOP_MIN = CNT_W'(EOP_BITS + FLAG_LEAD);
    localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_BITS + FLAG_LEAD);
    localparam logic [2:0]       ALIGNED = 3'(FLAG_LEAD % BYTE_W);
    localparam logic [2:0]       NB_SAT  = 3'(HOLD_N + 1);

    fr_state_t        st_q, st_d;
    logic [7:0]       shift_q;
    logic [2:0]       bitpos_q;
    logic [CNT_W-1:0] nbits_q;
    logic [2:0]       nbytes_q;
    logic [15:0]      crc_q;
    logic [7:0]       hold_q [HOLD_N];

    logic [7:0] new_byte;
    logic       byte_done, addr_ok;
    end_code_t  close_code;

    always_comb begin
        new_byte  = {rx_bit, shift_q[7:1]};
        byte_done = ev_data && (bitpos_q == 3'd7);
        if (new_byte == 8'hFF)  addr_ok = 1'b1;
        else if (filt_narrow)   addr_ok = (new_byte[7:2] == addr_hi[6:1]);
        else                    addr_ok = (new_byte[7:1] == addr_hi);
        if (nbits_q < LEN_MIN)                            close_code = END_SHORT;
        else if (bitpos_q != ALIGNED || crc_q != CRC_GOOD) close_code = END_BAD;
        else                                              close_code = END_GOOD;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_HUNT: if (ev_flag) st_d = FR_OPEN;
            FR_OPEN: if (ev_abort) st_d = FR_HUNT;
                     else if (byte_done && nbytes_q == 3'd0 && filt_en && !addr_ok) st_d = FR_SKIP;
            FR_SKIP: if (ev_abort) st_d = FR_HUNT;
                     else if (ev_flag) st_d = FR_OPEN;
            default: st_d = FR_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_HUNT;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bitpos_q    <= '0;
            nbits_q     <= '0;
            nbytes_q    <= '0;
            crc_q       <= CRC_PRESET;
            for (int i = 0; i < HOLD_N; i++) hold_q[i] <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_first   <= 1'b0;
            out_last    <= 1'b0;
            end_status  <= END_GOOD;
            eop         <= 1'b0;
            abort_frame <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            if (bit_en) begin
                eop         <= 1'b0;
                abort_frame <= 1'b0;
            end
            if (ev_abort || ev_flag) begin
                if (st_q == FR_OPEN) begin
                    if (ev_abort) begin
                        eop         <= 1'b1;
                        end_status  <= END_ABORT;
                        abort_frame <= (nbytes_q == NB_SAT);
                    end else begin
                        if (nbytes_q == NB_SAT) begin
                            out_valid <= 1'b1;
                            out_data  <= hold_q[HOLD_N-1];
                            out_last  <= 1'b1;
                        end
                        if (nbits_q >= EOP_MIN) begin
                            eop        <= 1'b1;
                            end_status <= close_code;
                        end
                    end
                end
                bitpos_q <= '0;
                nbits_q  <= '0;
                nbytes_q <= '0;
                crc_q    <= CRC_PRESET;
            end else if (ev_data && st_q != FR_HUNT) begin
                shift_q  <= new_byte;
                bitpos_q <= bitpos_q + 1'b1;
                if (nbits_q != '1) nbits_q <= nbits_q + 1'b1;
                if (byte_done) begin
                    crc_q     <= crc_byte(crc_q, new_byte);
                    hold_q[0] <= new_byte;
                    for (int i = 1; i < HOLD_N; i++) hold_q[i] <= hold_q[i-1];
                    if (nbytes_q != NB_SAT) nbytes_q <= nbytes_q + 1'b1;
                    if (st_q == FR_OPEN && nbytes_q >= 3'(HOLD_N)) begin
                        out_valid <= 1'b1;
                        out_data  <= hold_q[HOLD_N-1];
                        out_first <= (nbytes_q == 3'(HOLD_N));
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       filt_en,
    input  logic       filt_narrow,
    input  logic [6:0] addr_hi,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic [1:0] end_status,
    output logic       eop,
    output logic       abort_frame,
    output logic       line_abort,
    output logic       line_idle
);
    logic      ev_data, ev_flag, ev_abort;
    end_code_t code_w;

    hdlc_rx_line u_line (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ev_data(ev_data), .ev_flag(ev_flag), .ev_abort(ev_abort),
        .line_abort(line_abort), .line_idle(line_idle)
    );

    hdlc_rx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ev_data(ev_data), .ev_flag(ev_flag), .ev_abort(ev_abort),
        .filt_en(filt_en), .filt_narrow(filt_narrow), .addr_hi(addr_hi),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .end_status(code_w), .eop(eop),
        .abort_frame(abort_frame)
    );

    assign end_status = code_w;
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       out_valid,
    input logic       out_first,
    input logic       out_last,
    input logic [1:0] end_status,
    input logic       eop,
    input logic       abort_frame,
    input logic       line_abort,
    input logic       line_idle
);
    p_abort_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_frame |-> (eop && end_status == 2'd3));

    p_last_has_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (eop && end_status != 2'd3));

    p_eop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(eop));

    p_idle_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> line_abort);

    p_valid_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en));

    p_valid_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_first_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> (out_valid && !out_last));
endmodule

bind hdlc_rx hdlc_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_valid(out_valid),
    .out_first(out_first), .out_last(out_last), .end_status(end_status),
    .eop(eop), .abort_frame(abort_frame), .line_abort(line_abort),
    .line_idle(line_idle)
);

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
    logic       filt_en = 1'b0, filt_narrow = 1'b0;
    logic [6:0] addr_hi = '0;
    logic       out_valid, out_first, out_last, eop, abort_frame, line_abort, line_idle;
    logic [7:0] out_data;
    logic [1:0] end_status;

    hdlc_rx dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .filt_en(filt_en), .filt_narrow(filt_narrow), .addr_hi(addr_hi),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .end_status(end_status), .eop(eop),
        .abort_frame(abort_frame), .line_abort(line_abort), .line_idle(line_idle)
    );

    int n_chk = 0, n_fail = 0, tx_ones = 0;
    logic [7:0] fbuf [0:15];
    logic [7:0] o_data [0:63];
    logic       o_first [0:63];
    logic       o_last [0:63];
    int         o_n = 0, eop_n = 0;
    logic [1:0] eop_st = '0;
    logic       eop_af = 1'b0, eop_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && o_n < 64) begin
                o_data[o_n]  = out_data;
                o_first[o_n] = out_first;
                o_last[o_n]  = out_last;
                o_n++;
            end
            if (eop && !eop_prev) begin
                eop_n++;
                eop_st = end_status;
                eop_af = abort_frame;
            end
            eop_prev = eop;
        end
    end

    function automatic logic [15:0] fcs_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_flag();
        send_bit(0);
        for (int i = 0; i < 6; i++) send_bit(1);
        send_bit(0);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i]);
            if (b[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
            end else tx_ones = 0;
        end
    endtask

    task automatic send_frame(input int n, input logic [15:0] err);
        logic [15:0] c = 16'hFFFF;
        send_flag();
        for (int i = 0; i < n; i++) begin
            send_byte(fbuf[i]);
            c = fcs_upd(c, fbuf[i]);
        end
        c = ~c ^ err;
        send_byte(c[7:0]);
        send_byte(c[15:8]);
        send_flag();
        settle();
    endtask

    task automatic expect_bytes(input string req, input int mark, input int n);
        chk(req, o_n - mark, n);
        for (int i = 0; i < n; i++) begin
            if (mark + i < 64) begin
                chk(req, o_data[mark+i], fbuf[i]);
                chk(req, o_first[mark+i], (i == 0) ? 1 : 0);
                chk(req, o_last[mark+i], (i == n - 1) ? 1 : 0);
            end
        end
    endtask

    task automatic t_reset();
        chk("R13 reset out_valid", out_valid, 0);
        chk("R13 reset eop", eop, 0);
        chk("R13 reset line_abort", line_abort, 0);
        chk("R13 reset line_idle", line_idle, 0);
    endtask

    task automatic t_good();
        int mark = o_n, e = eop_n;
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); settle();
        chk("R1 no output before flag", o_n - mark, 0);
        fbuf[0] = 8'h3E; fbuf[1] = 8'hFF; fbuf[2] = 8'h7E; fbuf[3] = 8'hF8;
        send_frame(4, 16'h0000);
        expect_bytes("R2 R7 good frame bytes", mark, 4);
        chk("R10 eop on close", eop_n - e, 1);
        chk("R6 good residue code", eop_st, 0);
        mark = o_n; e = eop_n;
        send_flag(); send_flag(); settle();
        chk("R1 back-to-back flags give no bytes", o_n - mark, 0);
        chk("R1 back-to-back flags give no eop", eop_n - e, 0);
    endtask

    task automatic t_badcrc();
        int mark = o_n;
        fbuf[0] = 8'h01; fbuf[1] = 8'h02; fbuf[2] = 8'h03; fbuf[3] = 8'h04; fbuf[4] = 8'hA5;
        send_frame(5, 16'h0100);
        expect_bytes("R7 bytes of bad frame", mark, 5);
        chk("R6 bad residue code", eop_st, 1);
    endtask

    task automatic t_short();
        int mark = o_n, e = eop_n;
        send_flag();
        for (int i = 0; i < 3; i++) send_byte(8'h55);
        send_flag(); settle();
        chk("R11 short eop", eop_n - e, 1);
        chk("R11 short code", eop_st, 2);
        chk("R11 short no bytes", o_n - mark, 0);
        e = eop_n;
        for (int i = 0; i < 2; i++) send_byte(8'h55);
        send_flag(); settle();
        chk("R10 under 24 bits no eop", eop_n - e, 0);
    endtask

    task automatic t_unaligned();
        logic [15:0] c = 16'hFFFF;
        int e = eop_n;
        fbuf[0] = 8'h10; fbuf[1] = 8'h20; fbuf[2] = 8'h30; fbuf[3] = 8'h40;
        send_flag();
        for (int i = 0; i < 4; i++) begin send_byte(fbuf[i]); c = fcs_upd(c, fbuf[i]); end
        c = ~c;
        send_byte(c[7:0]); send_byte(c[15:8]);
        send_bit(0); send_bit(1); send_bit(0); tx_ones = 0;
        send_flag(); settle();
        chk("R12 unaligned eop", eop_n - e, 1);
        chk("R12 unaligned code", eop_st, 1);
    endtask

    task automatic t_abort();
        int mark, e;
        mark = o_n; e = eop_n;
        send_flag();
        for (int i = 0; i < 5; i++) send_byte(8'h11);
        for (int i = 0; i < 8; i++) send_bit(1);
        settle();
        chk("R3 abort eop", eop_n - e, 1);
        chk("R3 abort code", eop_st, 3);
        chk("R4 abort after five bytes", eop_af, 1);
        chk("R3 line_abort set", line_abort, 1);
        chk("R3 bytes before abort", o_n - mark, 2);
        chk("R3 no last marker", (o_n > 0) ? o_last[o_n-1] : 0, 0);
        send_flag(); settle();
        chk("R3 line_abort cleared by flag", line_abort, 0);
        e = eop_n;
        for (int i = 0; i < 2; i++) send_byte(8'h11);
        for (int i = 0; i < 8; i++) send_bit(1);
        settle();
        chk("R3 short abort eop", eop_n - e, 1);
        chk("R4 abort after two bytes", eop_af, 0);
    endtask

    task automatic t_idle();
        send_flag();
        for (int i = 0; i < 14; i++) send_bit(1);
        settle();
        chk("R5 idle low after 14 ones", line_idle, 0);
        send_bit(1); settle();
        chk("R5 idle high after 15 ones", line_idle, 1);
        send_bit(0); settle();
        chk("R5 idle cleared by zero", line_idle, 0);
        chk("R3 abort held until flag", line_abort, 1);
        send_flag(); settle();
    endtask

    task automatic t_addr();
        int mark, e;
        fbuf[1] = 8'h9C; fbuf[2] = 8'h00; fbuf[3] = 8'h5A;
        @(negedge clk); filt_en = 1'b1; filt_narrow = 1'b0; addr_hi = 7'h12;
        mark = o_n; fbuf[0] = 8'h25; send_frame(4, 16'h0000);
        expect_bytes("R8 match ignoring bit 0", mark, 4);
        mark = o_n; e = eop_n; fbuf[0] = 8'h26; send_frame(4, 16'h0000);
        chk("R8 mismatch no bytes", o_n - mark, 0);
        chk("R8 mismatch no eop", eop_n - e, 0);
        mark = o_n; fbuf[0] = 8'hFF; send_frame(4, 16'h0000);
        expect_bytes("R8 all-ones accepted", mark, 4);
        @(negedge clk); filt_narrow = 1'b1;
        mark = o_n; fbuf[0] = 8'h26; send_frame(4, 16'h0000);
        expect_bytes("R9 narrow ignores bit 1", mark, 4);
        mark = o_n; fbuf[0] = 8'h2C; send_frame(4, 16'h0000);
        chk("R9 narrow mismatch rejected", o_n - mark, 0);
        @(negedge clk); filt_en = 1'b0; filt_narrow = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_good();
        t_badcrc();
        t_short();
        t_unaligned();
        t_abort();
        t_idle();
        t_addr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule